// File: doc/BRIEF.md
# Dual Hardware Stack Pointer Unit

This block manages an 8-bit stack pointer over a small register-file stack memory. The two upper pointer bits choose one of four independent stacks; the six lower bits choose a word inside that stack. In one clock cycle an operation can read the entry under the pointer, move the word field by a small signed step, and write data either where the pointer was or where it now points.

Steps that would carry out of, or borrow from, the six-bit word field raise a sticky stack error. The operation that caused the error is then cancelled: the pointer does not move and the memory is not written. A pointer of zero marks an empty stack. Reading the top entry of an empty stack is reported as underflow only when the operation asks for that check. The pointer can also be snapshotted by a save strobe, brought back from that snapshot by a restore strobe, or loaded directly from a 16-bit data bus.

Top module: `stkptr_unit`

## Requirements
- R1: After reset, `ptr` is 0, `stk_err` is 0 and `rd_data` is 0.
- R2: `ptr[7:6]` selects the stack and `ptr[5:0]` selects the word. The memory is addressed by the whole 8-bit pointer, so equal word numbers in different stacks are separate storage.
- R3: When `op_valid` and `ref_top` are both set, `rd_data` shows, after the clock edge, the word stored at the pointer value from before the step. A write made in the same operation does not affect this read. Without `ref_top`, `rd_data` holds its value.
- R4: `step` is a 3-bit two's-complement value from -4 to +3. It is added to `ptr[5:0]`, and `ptr[7:6]` never changes as a result of a step.
- R5: When `wr_en` is set, `wr_at_new`=0 writes `wr_data` at the old pointer and `wr_at_new`=1 writes it at the stepped pointer.
- R6: A step that takes the word field above 63 raises `stk_err`. The pointer and the memory are then left unchanged.
- R7: A step that takes the word field below 0 raises `stk_err`. The pointer and the memory are then left unchanged.
- R8: When the whole pointer is 0, the empty-stack error is raised only if both `ref_top` and `chk_en` are set. A step with no reference, a reference with `chk_en`=0, or a word-0 pointer in a nonzero stack raises no error.
- R9: `stk_err` stays set until `err_clr`. If a new error arrives in the same cycle as `err_clr`, the flag stays set.
- R10: `save_ptr` captures the pointer value from before that cycle's update. `restore_ptr` reloads the pointer from the captured value.
- R11: When `ld_en` is set, the pointer is loaded from `ld_data[7:0]`, and the upper bits of the bus are ignored.
- R12: `restore_ptr` takes priority over `ld_en`, and `ld_en` takes priority over `op_valid`. An operation overridden in this way does not read, write or raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Perform a stack operation this cycle |
| step | input | 3 | Signed step applied to the word field |
| ref_top | input | 1 | Operation reads the entry under the pointer |
| chk_en | input | 1 | Enable the empty-stack underflow check |
| wr_en | input | 1 | Operation writes `wr_data` |
| wr_at_new | input | 1 | 1: write at the stepped pointer, 0: write at the old pointer |
| wr_data | input | 16 | Data to write |
| ld_en | input | 1 | Load the pointer from `ld_data` |
| ld_data | input | 16 | Load bus; the low 8 bits are used |
| save_ptr | input | 1 | Capture the current pointer |
| restore_ptr | input | 1 | Reload the pointer from the captured copy |
| err_clr | input | 1 | Clear the error flag |
| rd_data | output | 16 | Registered read data |
| ptr | output | 8 | Current stack pointer |
| stk_err | output | 1 | Sticky stack error flag |

## Verification
The hardest cases to reach are the cancelled operations. An error or a priority override must leave the memory untouched, and no port shows a write that did not happen. To expose this, the stimulus first stores a known word at the address the cancelled write would have hit. It then issues the failing or overridden operation with a different data value, and afterwards reads the address back with a separate reference. The stimulus also drives the pointer to the edges of the word field: word 63 with a positive step, word 0 with a negative step, and pointer 0 against a pointer of 0x40. It does this through direct loads, so that each edge is reached in a single cycle.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
  // Where the next pointer value comes from
  typedef enum logic [1:0] {
    PSRC_HOLD    = 2'd0,
    PSRC_STEP    = 2'd1,
    PSRC_LOAD    = 2'd2,
    PSRC_RESTORE = 2'd3
  } ptr_src_e;

  // Which address a write uses
  typedef enum logic {
    WA_OLD = 1'b0,
    WA_NEW = 1'b1
  } wr_addr_e;
endpackage

// File: rtl/stkptr_step_calc.sv
module stkptr_step_calc #(
  parameter int WORD_W = 6,
  parameter int STEP_W = 3
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [WORD_W-1:0] word_o,
  output logic              carry_o,
  output logic              borrow_o
);
  // Two guard bits: one for the carry, one for the sign
  localparam int SUM_W = WORD_W + 2;

  function automatic logic [SUM_W-1:0] add_step(input logic [WORD_W-1:0] w,
                                                input logic [STEP_W-1:0] s);
    logic [SUM_W-1:0] wx;
    logic [SUM_W-1:0] sx;
    wx = {2'b00, w};
    sx = {{(SUM_W-STEP_W){s[STEP_W-1]}}, s};
    return wx + sx;
  endfunction

  logic [SUM_W-1:0] sum;

  assign sum      = add_step(word_i, step_i);
  assign word_o   = sum[WORD_W-1:0];
  assign borrow_o = sum[SUM_W-1];
  assign carry_o  = ~sum[SUM_W-1] & sum[WORD_W];
endmodule

// File: rtl/stkptr_ctrl.sv
module stkptr_ctrl
  import stkptr_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             op_valid_i,
  input  logic             ref_top_i,
  input  logic             chk_en_i,
  input  logic             load_i,
  input  logic             restore_i,
  input  logic             carry_i,
  input  logic             borrow_i,
  output ptr_src_e         src_o,
  output logic             step_go_o,
  output logic             err_evt_o
);
  logic empty;

  assign empty     = (ptr_i == '0);
  assign step_go_o = op_valid_i & ~restore_i & ~load_i;
  assign err_evt_o = step_go_o & (carry_i | borrow_i | (empty & ref_top_i & chk_en_i));

  always_comb begin
    if (restore_i)
      src_o = PSRC_RESTORE;
    else if (load_i)
      src_o = PSRC_LOAD;
    else if (step_go_o && !err_evt_o)
      src_o = PSRC_STEP;
    else
      src_o = PSRC_HOLD;
  end
endmodule

// File: rtl/stkptr_stack_mem.sv
module stkptr_stack_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      cells[wr_addr] <= wr_data;
  end

  // The read register samples the cells before this edge's write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= cells[rd_addr];
  end
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  parameter int WORD_W = 6,
  parameter int STEP_W = 3,
  parameter int LD_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [STEP_W-1:0]         step,
  input  logic                      ref_top,
  input  logic                      chk_en,
  input  logic                      wr_en,
  input  logic                      wr_at_new,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      ld_en,
  input  logic [LD_W-1:0]           ld_data,
  input  logic                      save_ptr,
  input  logic                      restore_ptr,
  input  logic                      err_clr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [SEL_W+WORD_W-1:0]   ptr,
  output logic                      stk_err
);
  localparam int PTR_W = SEL_W + WORD_W;

  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  saved_q;
  logic [PTR_W-1:0]  ptr_d;
  logic [PTR_W-1:0]  stepped_ptr;
  logic [WORD_W-1:0] new_word;
  logic              carry;
  logic              borrow;
  logic              step_go;
  logic              err_evt;
  logic              err_q;
  ptr_src_e          src;
  wr_addr_e          wsel;
  logic              mem_we;
  logic [PTR_W-1:0]  mem_waddr;

  if (LD_W > PTR_W) begin : g_ld_hi
    logic unused_ld_hi;
    assign unused_ld_hi = ^ld_data[LD_W-1:PTR_W];
  end

  stkptr_step_calc #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_step (
    .word_i   (ptr_q[WORD_W-1:0]),
    .step_i   (step),
    .word_o   (new_word),
    .carry_o  (carry),
    .borrow_o (borrow)
  );

  stkptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .ptr_i      (ptr_q),
    .op_valid_i (op_valid),
    .ref_top_i  (ref_top),
    .chk_en_i   (chk_en),
    .load_i     (ld_en),
    .restore_i  (restore_ptr),
    .carry_i    (carry),
    .borrow_i   (borrow),
    .src_o      (src),
    .step_go_o  (step_go),
    .err_evt_o  (err_evt)
  );

  assign stepped_ptr = {ptr_q[PTR_W-1:WORD_W], new_word};
  assign wsel        = wr_addr_e'(wr_at_new);
  assign mem_we      = step_go & wr_en & ~err_evt;
  assign mem_waddr   = (wsel == WA_NEW) ? stepped_ptr : ptr_q;

  stkptr_stack_mem #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (step_go & ref_top),
    .rd_addr (ptr_q),
    .rd_data (rd_data),
    .wr_en   (mem_we),
    .wr_addr (mem_waddr),
    .wr_data (wr_data)
  );

  always_comb begin
    unique case (src)
      PSRC_STEP:    ptr_d = stepped_ptr;
      PSRC_LOAD:    ptr_d = ld_data[PTR_W-1:0];
      PSRC_RESTORE: ptr_d = saved_q;
      default:      ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      saved_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      if (save_ptr)
        saved_q <= ptr_q;
      if (err_evt)
        err_q <= 1'b1;
      else if (err_clr)
        err_q <= 1'b0;
    end
  end

  assign ptr     = ptr_q;
  assign stk_err = err_q;
endmodule

module stkptr_unit_chk #(
  parameter int PTR_W  = 8,
  parameter int WORD_W = 6,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restore_ptr,
  input logic              ld_en,
  input logic              ref_top,
  input logic              chk_en,
  input logic              err_clr,
  input logic [STEP_W-1:0] step,
  input logic [PTR_W-1:0]  ld_low,
  input logic [PTR_W-1:0]  ptr,
  input logic              stk_err,
  input logic [PTR_W-1:0]  saved_q,
  input logic              step_go,
  input logic              err_evt
);
  AST_SEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    step_go |=> ptr[PTR_W-1:WORD_W] == $past(ptr[PTR_W-1:WORD_W])); // R4

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    step_go && (ptr[WORD_W-1:0] == '1) && !step[STEP_W-1] && (step != '0) |-> err_evt); // R6

  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> $stable(ptr)); // R7

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    step_go && (ptr == '0) && !(ref_top && chk_en) && !step[STEP_W-1] |-> !err_evt); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_err || err_evt) && !err_clr |=> stk_err); // R9

  AST_RESTORE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    restore_ptr |=> ptr == $past(saved_q)); // R10

  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !restore_ptr |=> ptr == $past(ld_low)); // R11

  AST_PRIO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_ptr || ld_en) |-> !step_go && !err_evt); // R12
endmodule

bind stkptr_unit stkptr_unit_chk #(
  .PTR_W(PTR_W), .WORD_W(WORD_W), .STEP_W(STEP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restore_ptr (restore_ptr),
  .ld_en       (ld_en),
  .ref_top     (ref_top),
  .chk_en      (chk_en),
  .err_clr     (err_clr),
  .step        (step),
  .ld_low      (ld_data[PTR_W-1:0]),
  .ptr         (ptr),
  .stk_err     (stk_err),
  .saved_q     (saved_q),
  .step_go     (step_go),
  .err_evt     (err_evt)
);

// File: tb/test_stkptr_unit.sv
module test_stkptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  step = '0;
  logic        ref_top = 1'b0;
  logic        chk_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_at_new = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_data = '0;
  logic        save_ptr = 1'b0;
  logic        restore_ptr = 1'b0;
  logic        err_clr = 1'b0;
  logic [15:0] rd_data;
  logic [7:0]  ptr;
  logic        stk_err;

  always #5 clk = ~clk;

  stkptr_unit i_stkptr_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .step(step),
    .ref_top(ref_top), .chk_en(chk_en), .wr_en(wr_en), .wr_at_new(wr_at_new),
    .wr_data(wr_data), .ld_en(ld_en), .ld_data(ld_data), .save_ptr(save_ptr),
    .restore_ptr(restore_ptr), .err_clr(err_clr), .rd_data(rd_data),
    .ptr(ptr), .stk_err(stk_err)
  );

  typedef struct packed {
    logic [7:0]  p;
    logic        e;
    logic [15:0] d;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  // Reference model state
  logic [7:0]  mp = '0;
  logic [7:0]  ms = '0;
  logic        me = 1'b0;
  logic [15:0] md = '0;
  logic [15:0] mm [256];

  // Monitor: compare one expected item per falling edge
  exp_t  cur;
  string ctag;
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur  = q.pop_front();
      ctag = tq.pop_front();
      total++;
      if (ptr !== cur.p || stk_err !== cur.e || rd_data !== cur.d) begin
        bad++;
        $display("FAIL %s: actual ptr=%h err=%b rd=%h expected ptr=%h err=%b rd=%h",
                 ctag, ptr, stk_err, rd_data, cur.p, cur.e, cur.d);
      end
    end
  end

  task automatic drive(bit v, int stp, bit rf, bit ck, bit we, bit wm,
                       logic [15:0] wd, bit ld, logic [15:0] ldd,
                       bit sv, bit rs, bit ec, string tag);
    int         w;
    bit         go;
    bit         er;
    logic [7:0] np;
    exp_t       x;
    @(negedge clk);
    op_valid = v; step = stp[2:0]; ref_top = rf; chk_en = ck;
    wr_en = we; wr_at_new = wm; wr_data = wd; ld_en = ld; ld_data = ldd;
    save_ptr = sv; restore_ptr = rs; err_clr = ec;
    w  = int'(mp[5:0]) + stp;
    go = v && !rs && !ld;
    er = go && (w > 63 || w < 0 || (mp == 8'h00 && rf && ck));
    np = mp;
    if (go && rf) md = mm[mp];
    if (rs) np = ms;
    else if (ld) np = ldd[7:0];
    else if (go && !er) begin
      np = {mp[7:6], w[5:0]};
      if (we) begin
        if (wm) mm[np] = wd;
        else    mm[mp] = wd;
      end
    end
    if (er) me = 1'b1;
    else if (ec) me = 1'b0;
    if (sv) ms = mp;
    mp = np;
    @(posedge clk);
    #1;
    op_valid = 0; ref_top = 0; chk_en = 0; wr_en = 0; wr_at_new = 0;
    ld_en = 0; save_ptr = 0; restore_ptr = 0; err_clr = 0;
    x.p = mp; x.e = me; x.d = md;
    q.push_back(x);
    tq.push_back(tag);
  endtask

  task automatic op(int stp, bit rf, bit ck, bit we, bit wm, logic [15:0] wd, string tag);
    drive(1, stp, rf, ck, we, wm, wd, 0, '0, 0, 0, 0, tag);
  endtask

  task automatic load(logic [15:0] v, string tag);
    drive(0, 0, 0, 0, 0, 0, '0, 1, v, 0, 0, 0, tag);
  endtask

  task automatic clr(string tag);
    drive(0, 0, 0, 0, 0, 0, '0, 0, '0, 0, 0, 1, tag);
  endtask

  initial begin
    exp_t r;
    for (int i = 0; i < 256; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    r.p = 8'h00; r.e = 1'b0; r.d = 16'h0000;
    q.push_back(r); tq.push_back("R1");
    // Pushes and write-address selection
    op(1, 0, 0, 1, 1, 16'hA001, "R5");
    op(1, 0, 0, 1, 1, 16'hA002, "R5");
    op(1, 0, 0, 1, 0, 16'hA003, "R5");
    op(0, 0, 0, 1, 0, 16'hA004, "R4");
    // Reads before pointer change
    op(-2, 1, 1, 0, 0, '0, "R3");
    op(0, 1, 1, 0, 0, '0, "R3");
    op(0, 1, 1, 1, 0, 16'hA005, "R3");
    op(0, 1, 1, 0, 0, '0, "R5");
    op(1, 1, 1, 0, 0, '0, "R3");
    op(-1, 1, 1, 0, 0, '0, "R4");
    // Underflow by borrow, sticky flag, memory untouched
    op(-2, 0, 0, 1, 0, 16'hBAD1, "R7");
    op(0, 0, 0, 0, 0, '0, "R9");
    op(0, 1, 1, 0, 0, '0, "R7");
    clr("R9");
    // Empty-stack check
    load(16'hAB00, "R11");
    op(0, 0, 0, 1, 0, 16'hB000, "R8");
    op(0, 1, 0, 0, 0, '0, "R8");
    op(0, 1, 1, 0, 0, '0, "R8");
    drive(1, 0, 1, 1, 0, 0, '0, 0, '0, 0, 0, 1, "R9");
    clr("R9");
    op(1, 0, 1, 0, 0, '0, "R8");
    // Overflow at top of word field
    load(16'h1C3E, "R11");
    op(1, 0, 0, 0, 0, '0, "R4");
    op(0, 0, 0, 1, 0, 16'hB002, "R5");
    op(1, 0, 0, 1, 0, 16'hBAD3, "R6");
    op(0, 1, 1, 0, 0, '0, "R6");
    clr("R9");
    load(16'hFF7D, "R11");
    op(2, 0, 0, 0, 0, '0, "R4");
    op(1, 0, 0, 1, 1, 16'hBAD4, "R6");
    clr("R9");
    op(-4, 0, 0, 0, 0, '0, "R4");
    // Independent stacks
    load(16'h0045, "R2");
    op(0, 0, 0, 1, 0, 16'hC001, "R2");
    load(16'h0005, "R2");
    op(0, 0, 0, 1, 0, 16'hC002, "R2");
    load(16'h0045, "R2");
    op(0, 1, 1, 0, 0, '0, "R2");
    load(16'h0005, "R2");
    op(0, 1, 1, 0, 0, '0, "R2");
    // Word 0 of a nonzero stack is not empty
    load(16'h0040, "R11");
    op(0, 0, 0, 1, 0, 16'hC003, "R5");
    op(0, 1, 1, 0, 0, '0, "R8");
    op(-1, 1, 1, 0, 0, '0, "R7");
    clr("R9");
    // Save and restore
    load(16'h0092, "R11");
    drive(0, 0, 0, 0, 0, 0, '0, 0, '0, 1, 0, 0, "R10");
    load(16'h0010, "R11");
    op(3, 0, 0, 0, 0, '0, "R4");
    drive(0, 0, 0, 0, 0, 0, '0, 0, '0, 0, 1, 0, "R10");
    drive(1, 1, 0, 0, 0, 0, '0, 0, '0, 1, 0, 0, "R10");
    op(2, 0, 0, 0, 0, '0, "R4");
    drive(0, 0, 0, 0, 0, 0, '0, 0, '0, 0, 1, 0, "R10");
    // Priority among restore, load and operation
    op(0, 0, 0, 1, 0, 16'hD000, "R5");
    drive(1, 1, 0, 0, 1, 0, 16'hBAD5, 1, 16'h0020, 0, 1, 0, "R12");
    op(0, 1, 1, 0, 0, '0, "R12");
    drive(1, 3, 0, 0, 1, 0, 16'hBAD6, 1, 16'hEE30, 0, 0, 0, "R12");
    drive(1, -4, 1, 1, 0, 0, '0, 1, 16'h0092, 0, 0, 0, "R12");
    op(0, 1, 1, 0, 0, '0, "R12");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule